// File: doc/BRIEF.md
# Descriptor-Chained Receive DMA Channel

This block is one receive channel of a packet DMA engine. It takes a byte stream with start and end markers and stores each packet in a memory buffer. Software describes each buffer with a four-word descriptor in memory, and descriptors are linked through a next pointer. The channel fetches a descriptor, fills the buffer, writes a status word back into the descriptor, and then follows the link. When the link is zero, the channel sets an end-of-queue flag in the status word and stops. Software can then append more descriptors and restart the channel by writing the head pointer again.

Three ports connect the channel to the rest of the chip. A word-wide request/grant memory port fetches descriptors and writes data and status. A small register port holds the controls. A byte stream port receives the packets. A receive credit counter limits how many descriptors the channel may fill. Packets longer than their buffer are dropped and counted. A descriptor that software has not handed over stops the channel and raises a sticky flag.

Top module: `rxdma_channel`

## Requirements
- R1: After reset, every register reads zero, and both `s_ready` and `mem_req` are low.
- R2: Register map, by word index on `reg_addr`: 0 control, 1 soft reset, 2 head pointer, 3 completion pointer, 4 credit, 5 status. When the channel is idle, enabled (control bit 0) and holds non-zero credit, writing a non-zero head address starts it. It then reads four words at head+0 (next pointer), head+4 (buffer pointer), head+8 (buffer length, bits 10:0) and head+12 (mode word). A memory request keeps its address and direction stable until `mem_gnt` is seen.
- R3: The bytes of a packet land little-endian from the start of the buffer, so byte i sits at byte offset i. Unused lanes of the final word are written as zero. Stream beats that arrive before a start marker are accepted and discarded.
- R4: On completion the channel writes the mode word with bit 31 (start of packet) set, bit 30 (end of packet) set, bit 29 (owner) clear, and the received byte count in bits 10:0. Bit 28 (end of queue) is set exactly when the next pointer is zero.
- R5: While a descriptor is in use, the head register reads its address. After completion the head moves to the next pointer and the channel continues. With a zero next pointer, the channel stops and the head reads zero.
- R6: After the channel has stopped, writing the head pointer again restarts it. A head write while the channel is busy is ignored.
- R7: If the fetched mode word has bit 29 clear, the channel moves no data and writes nothing. It sets status bit 0 and clears the head. Writing 1 to status bit 0 clears the flag.
- R8: A write to the credit register adds its value, saturating at the all-ones value. Each completed descriptor consumes one credit. No descriptor is started while the credit is zero.
- R9: With control bit 0 clear, no new descriptor is started and the stream is not accepted.
- R10: A packet longer than the buffer length is consumed through its end marker and dropped. Status bits 15:8 count such packets. The descriptor stays owned by the channel and receives the next packet.
- R11: Writing 1 to soft-reset bit 0 clears every register and the channel state. The bit reads zero again one cycle later.
- R12: A value written to the completion pointer register reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | ADDR_W | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Memory write data |
| mem_gnt | input | 1 | Memory grant; the access completes in that cycle |
| mem_rdata | input | 32 | Memory read data, valid with the grant |
| s_valid | input | 1 | Stream beat valid |
| s_data | input | 8 | Stream byte |
| s_sop | input | 1 | Start-of-packet marker |
| s_eop | input | 1 | End-of-packet marker |
| s_ready | output | 1 | Stream beat accepted |

## Verification
The assertions check on every cycle that memory requests hold until granted and that every written status word hands ownership back with both packet markers set. They also check that a final descriptor leaves the head at zero, that no descriptor starts without credit and enable, that each drop steps the overflow count once, that soft reset leaves everything cleared, and that an idle channel never accepts the stream. Only the bench scenarios can show byte placement in the buffer, the exact byte counts, the chaining order across descriptors, re-arming after end of queue, the refusal of a descriptor not handed over, and the discarding of bytes before a start marker.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;

  localparam int MODE_SOP = 31;
  localparam int MODE_EOP = 30;
  localparam int MODE_OWN = 29;
  localparam int MODE_EOQ = 28;
  localparam int LEN_W    = 11;

  localparam logic [2:0] RA_CTRL = 3'd0;
  localparam logic [2:0] RA_SRST = 3'd1;
  localparam logic [2:0] RA_HEAD = 3'd2;
  localparam logic [2:0] RA_CMPL = 3'd3;
  localparam logic [2:0] RA_FREE = 3'd4;
  localparam logic [2:0] RA_STAT = 3'd5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_RECV,
    ST_WR_DATA,
    ST_DROP,
    ST_WR_MODE
  } chan_state_t;

  // status word handed back to software: both markers, owner clear
  function automatic logic [31:0] f_status_word(input logic [LEN_W-1:0] cnt,
                                                input logic last);
    return {1'b1, 1'b1, 1'b0, last, 17'b0, cnt};
  endfunction

  // byte address of word number idx starting at base
  function automatic logic [31:0] f_step(input logic [31:0] base,
                                         input logic [LEN_W-1:0] idx);
    return base + {19'b0, idx, 2'b00};
  endfunction

endpackage

// File: rtl/rxdma_packer.sv
module rxdma_packer #(
  parameter int LANES = 4,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               load,
  input  logic [LANE_W-1:0]  lane,
  input  logic [7:0]         byte_in,
  output logic [8*LANES-1:0] word_out
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] lane_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  lane_q <= '0;
      else if (clr)                                lane_q <= '0;
      else if (load && lane == LANE_W'(g))         lane_q <= byte_in;
    end
    assign word_out[8*g +: 8] = lane_q;
  end

endmodule

// File: rtl/rxdma_regs.sv
module rxdma_regs
  import rxdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CRED_W = 8,
  parameter int OVF_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              eng_busy,
  input  logic              head_upd,
  input  logic [ADDR_W-1:0] head_nxt,
  input  logic              credit_take,
  input  logic              busyclr_set,
  input  logic              ovf_inc,
  output logic              chan_en,
  output logic [ADDR_W-1:0] head_q,
  output logic [CRED_W-1:0] credit_q,
  output logic              srst_q,
  output logic [OVF_W-1:0]  ovf_q
);

  logic        busyclr_q;
  logic [31:0] cmpl_q;
  logic        wr_ctrl, wr_srst, wr_head, wr_cmpl, wr_free, wr_stat;
  logic [CRED_W:0]   cred_sum;
  logic [CRED_W-1:0] cred_next;

  assign wr_ctrl = reg_we && reg_addr == RA_CTRL;
  assign wr_srst = reg_we && reg_addr == RA_SRST;
  assign wr_head = reg_we && reg_addr == RA_HEAD;
  assign wr_cmpl = reg_we && reg_addr == RA_CMPL;
  assign wr_free = reg_we && reg_addr == RA_FREE;
  assign wr_stat = reg_we && reg_addr == RA_STAT;

  always_comb begin
    cred_sum = {1'b0, credit_q} + (wr_free ? {1'b0, reg_wdata[CRED_W-1:0]} : '0);
    if (credit_take) cred_sum = cred_sum - 1'b1;
    cred_next = cred_sum[CRED_W] ? '1 : cred_sum[CRED_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_en   <= 1'b0;
      srst_q    <= 1'b0;
      head_q    <= '0;
      cmpl_q    <= '0;
      credit_q  <= '0;
      busyclr_q <= 1'b0;
      ovf_q     <= '0;
    end else if (srst_q) begin
      chan_en   <= 1'b0;
      srst_q    <= 1'b0;
      head_q    <= '0;
      cmpl_q    <= '0;
      credit_q  <= '0;
      busyclr_q <= 1'b0;
      ovf_q     <= '0;
    end else begin
      if (wr_srst && reg_wdata[0]) srst_q <= 1'b1;
      if (wr_ctrl)  chan_en <= reg_wdata[0];
      if (head_upd)                  head_q <= head_nxt;
      else if (wr_head && !eng_busy) head_q <= reg_wdata[ADDR_W-1:0];
      if (wr_cmpl)  cmpl_q <= reg_wdata;
      credit_q <= cred_next;
      if (busyclr_set)                     busyclr_q <= 1'b1;
      else if (wr_stat && reg_wdata[0])    busyclr_q <= 1'b0;
      if (ovf_inc) ovf_q <= ovf_q + 1'b1;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CTRL: reg_rdata[0] = chan_en;
      RA_SRST: reg_rdata[0] = srst_q;
      RA_HEAD: reg_rdata = 32'(head_q);
      RA_CMPL: reg_rdata = cmpl_q;
      RA_FREE: reg_rdata = 32'(credit_q);
      RA_STAT: begin
        reg_rdata[0]          = busyclr_q;
        reg_rdata[8 +: OVF_W] = ovf_q;
      end
      default: reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/rxdma_engine.sv
module rxdma_engine
  import rxdma_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              srst,
  input  logic              chan_en,
  input  logic [ADDR_W-1:0] head_q,
  input  logic              credit_nz,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_gnt,
  input  logic [31:0]       mem_rdata,
  input  logic              s_valid,
  input  logic              s_sop,
  input  logic              s_eop,
  output logic              s_ready,
  output logic              pk_load,
  output logic [1:0]        pk_lane,
  output logic              pk_clr,
  input  logic [31:0]       pk_word,
  output logic              head_upd,
  output logic [ADDR_W-1:0] head_nxt,
  output logic              credit_take,
  output logic              busyclr_set,
  output logic              ovf_inc,
  output logic              eng_busy,
  output logic              evt_start,
  output logic              evt_done
);

  chan_state_t       state_q;
  logic [ADDR_W-1:0] cur_q, next_q, buf_q;
  logic [LEN_W-1:0]  blen_q, cnt_q;
  logic [1:0]        widx_q;
  logic              in_pkt_q, last_q;
  logic              beat, take, room, word_full, fetch_last;

  assign beat       = s_valid && s_ready;
  assign take       = state_q == ST_RECV && beat && (in_pkt_q || s_sop);
  assign room       = cnt_q != blen_q;
  assign word_full  = pk_load && (cnt_q[1:0] == 2'd3 || s_eop);
  assign fetch_last = state_q == ST_FETCH && mem_gnt && widx_q == 2'd3;

  assign pk_load     = take && room;
  assign pk_lane     = cnt_q[1:0];
  assign pk_clr      = srst || (state_q == ST_WR_DATA && mem_gnt) || (take && !room);
  assign ovf_inc     = take && !room && !srst;
  assign busyclr_set = fetch_last && !mem_rdata[MODE_OWN] && !srst;
  assign evt_done    = state_q == ST_WR_MODE && mem_gnt && !srst;
  assign evt_start   = state_q == ST_IDLE && chan_en && head_q != '0 && credit_nz && !srst;
  assign head_upd    = evt_done || busyclr_set;
  assign head_nxt    = evt_done ? next_q : '0;
  assign credit_take = evt_done;
  assign eng_busy    = state_q != ST_IDLE;

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    s_ready   = 1'b0;
    case (state_q)
      ST_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = ADDR_W'(f_step(32'(cur_q), LEN_W'(widx_q)));
      end
      ST_RECV, ST_DROP: s_ready = 1'b1;
      ST_WR_DATA: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = ADDR_W'(f_step(32'(buf_q), (cnt_q - 1'b1) >> 2));
        mem_wdata = pk_word;
      end
      ST_WR_MODE: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = ADDR_W'(f_step(32'(cur_q), LEN_W'(3)));
        mem_wdata = f_status_word(cnt_q, next_q == '0);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cur_q    <= '0;
      next_q   <= '0;
      buf_q    <= '0;
      blen_q   <= '0;
      cnt_q    <= '0;
      widx_q   <= '0;
      in_pkt_q <= 1'b0;
      last_q   <= 1'b0;
    end else if (srst) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      widx_q   <= '0;
      in_pkt_q <= 1'b0;
      last_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (evt_start) begin
          cur_q   <= head_q;
          widx_q  <= '0;
          state_q <= ST_FETCH;
        end
        ST_FETCH: if (mem_gnt) begin
          case (widx_q)
            2'd0:    next_q <= mem_rdata[ADDR_W-1:0];
            2'd1:    buf_q  <= mem_rdata[ADDR_W-1:0];
            2'd2:    blen_q <= mem_rdata[LEN_W-1:0];
            default: ;
          endcase
          widx_q <= widx_q + 1'b1;
          if (fetch_last) begin
            cnt_q    <= '0;
            in_pkt_q <= 1'b0;
            state_q  <= mem_rdata[MODE_OWN] ? ST_RECV : ST_IDLE;
          end
        end
        ST_RECV: if (take) begin
          if (!room) begin
            cnt_q    <= '0;
            in_pkt_q <= 1'b0;
            state_q  <= s_eop ? ST_RECV : ST_DROP;
          end else begin
            cnt_q    <= cnt_q + 1'b1;
            in_pkt_q <= 1'b1;
            last_q   <= s_eop;
            if (word_full) state_q <= ST_WR_DATA;
          end
        end
        ST_WR_DATA: if (mem_gnt) state_q <= last_q ? ST_WR_MODE : ST_RECV;
        ST_DROP:    if (beat && s_eop) state_q <= ST_RECV;
        ST_WR_MODE: if (mem_gnt) state_q <= ST_IDLE;
        default:    state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rxdma_channel.sv
module rxdma_channel
  import rxdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CRED_W = 8,
  parameter int OVF_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_gnt,
  input  logic [31:0]       mem_rdata,
  input  logic              s_valid,
  input  logic [7:0]        s_data,
  input  logic              s_sop,
  input  logic              s_eop,
  output logic              s_ready
);

  logic              chan_en, srst_q, eng_busy;
  logic [ADDR_W-1:0] head_val, head_nxt;
  logic [CRED_W-1:0] credit_val;
  logic [OVF_W-1:0]  ovf_cnt;
  logic              head_upd, credit_take, busyclr_set, ovf_inc;
  logic              evt_start, evt_done;
  logic              pk_load, pk_clr;
  logic [1:0]        pk_lane;
  logic [31:0]       pk_word;

  rxdma_regs #(.ADDR_W(ADDR_W), .CRED_W(CRED_W), .OVF_W(OVF_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .eng_busy    (eng_busy),
    .head_upd    (head_upd),
    .head_nxt    (head_nxt),
    .credit_take (credit_take),
    .busyclr_set (busyclr_set),
    .ovf_inc     (ovf_inc),
    .chan_en     (chan_en),
    .head_q      (head_val),
    .credit_q    (credit_val),
    .srst_q      (srst_q),
    .ovf_q       (ovf_cnt)
  );

  rxdma_engine #(.ADDR_W(ADDR_W)) u_engine (
    .clk         (clk),
    .rst_n       (rst_n),
    .srst        (srst_q),
    .chan_en     (chan_en),
    .head_q      (head_val),
    .credit_nz   (credit_val != '0),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_gnt     (mem_gnt),
    .mem_rdata   (mem_rdata),
    .s_valid     (s_valid),
    .s_sop       (s_sop),
    .s_eop       (s_eop),
    .s_ready     (s_ready),
    .pk_load     (pk_load),
    .pk_lane     (pk_lane),
    .pk_clr      (pk_clr),
    .pk_word     (pk_word),
    .head_upd    (head_upd),
    .head_nxt    (head_nxt),
    .credit_take (credit_take),
    .busyclr_set (busyclr_set),
    .ovf_inc     (ovf_inc),
    .eng_busy    (eng_busy),
    .evt_start   (evt_start),
    .evt_done    (evt_done)
  );

  rxdma_packer #(.LANES(4)) u_packer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (pk_clr),
    .load     (pk_load),
    .lane     (pk_lane),
    .byte_in  (s_data),
    .word_out (pk_word)
  );

endmodule

// File: rtl/rxdma_channel_chk.sv
module rxdma_channel_chk #(
  parameter int ADDR_W = 32,
  parameter int CRED_W = 8,
  parameter int OVF_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_wdata,
  input logic              mem_gnt,
  input logic              s_ready,
  input logic              eng_busy,
  input logic              evt_start,
  input logic              evt_done,
  input logic              ovf_inc,
  input logic [OVF_W-1:0]  ovf_cnt,
  input logic [ADDR_W-1:0] head_val,
  input logic [CRED_W-1:0] credit_val,
  input logic              chan_en,
  input logic              srst_q
);

  logic unused_wdata_bits;
  assign unused_wdata_bits = ^mem_wdata[27:0];

  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt && !srst_q |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  p_status_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_done |-> mem_we && mem_wdata[31] && mem_wdata[30] && !mem_wdata[29]);

  p_eoq_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_done && mem_wdata[28] |=> head_val == '0);

  p_credit_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_start |-> credit_val != '0);

  p_enable_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_start |-> chan_en);

  p_idle_no_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_busy |-> !s_ready);

  p_ovf_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_inc |=> ovf_cnt == OVF_W'($past(ovf_cnt) + 1'b1));

  p_srst_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> head_val == '0 && credit_val == '0 && !eng_busy && !chan_en);

endmodule

bind rxdma_channel rxdma_channel_chk #(
  .ADDR_W(ADDR_W), .CRED_W(CRED_W), .OVF_W(OVF_W)
) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .mem_gnt    (mem_gnt),
  .s_ready    (s_ready),
  .eng_busy   (eng_busy),
  .evt_start  (evt_start),
  .evt_done   (evt_done),
  .ovf_inc    (ovf_inc),
  .ovf_cnt    (ovf_cnt),
  .head_val   (head_val),
  .credit_val (credit_val),
  .chan_en    (chan_en),
  .srst_q     (srst_q)
);

// File: tb/test_rxdma_channel.sv
module test_rxdma_channel;

  localparam int A_CTRL = 0, A_SRST = 1, A_HEAD = 2, A_CMPL = 3, A_FREE = 4, A_STAT = 5;
  localparam logic [31:0] OWNED = 32'h2000_0000;
  // vector: buffer length in [26:16], packet length in [10:0]
  localparam int NVEC = 6;
  localparam logic [31:0] VECS [NVEC] = '{
    {5'd0, 11'd16, 5'd0, 11'd16},
    {5'd0, 11'd16, 5'd0, 11'd5},
    {5'd0, 11'd64, 5'd0, 11'd1},
    {5'd0, 11'd8,  5'd0, 11'd9},
    {5'd0, 11'd32, 5'd0, 11'd13},
    {5'd0, 11'd4,  5'd0, 11'd30}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we, mem_gnt;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        s_valid = 1'b0, s_sop = 1'b0, s_eop = 1'b0, s_ready;
  logic [7:0]  s_data = '0;
  logic [31:0] mem [256];
  logic [1:0]  gcnt = '0;
  int checks = 0;
  int failures = 0;
  logic [31:0] rv;

  always #10 clk = ~clk;

  rxdma_channel i_rxdma_channel (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .s_valid(s_valid),
    .s_data(s_data), .s_sop(s_sop), .s_eop(s_eop), .s_ready(s_ready)
  );

  // memory model: one stall cycle in four
  always @(negedge clk) gcnt <= gcnt + 1'b1;
  assign mem_gnt   = gcnt != 2'd2;
  assign mem_rdata = mem[mem_addr[9:2]];
  always @(posedge clk) if (mem_req && mem_we && mem_gnt) mem[mem_addr[9:2]] <= mem_wdata;

  function automatic logic [31:0] exp_word(input logic [7:0] seed, input int len, input int w);
    logic [31:0] r = '0;
    for (int l = 0; l < 4; l++)
      if (w * 4 + l < len) r[8*l +: 8] = seed + 8'(w * 4 + l);
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input int a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input int a, output logic [31:0] d);
    reg_addr = 3'(a);
    #1 d = reg_rdata;
  endtask

  task automatic drive_byte(input logic [7:0] d, input logic sop, input logic eop);
    s_valid = 1'b1; s_data = d; s_sop = sop; s_eop = eop;
    while (!s_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic send_pkt(input int len, input logic [7:0] seed, input int junk);
    for (int j = 0; j < junk; j++) drive_byte(8'hEE, 1'b0, 1'b0);
    for (int i = 0; i < len; i++) drive_byte(seed + 8'(i), i == 0, i == len - 1);
    s_valid = 1'b0; s_sop = 1'b0; s_eop = 1'b0;
  endtask

  task automatic wait_head(input logic [31:0] target, input bit until_eq);
    logic [31:0] h;
    for (int k = 0; k < 3000; k++) begin
      reg_rd(A_HEAD, h);
      if ((h == target) == until_eq) break;
      @(negedge clk);
    end
  endtask

  task automatic set_desc(input int a, input logic [31:0] nxt, input logic [31:0] bp,
                          input int blen, input logic [31:0] mode);
    mem[a >> 2] = nxt; mem[(a >> 2) + 1] = bp;
    mem[(a >> 2) + 2] = 32'(blen); mem[(a >> 2) + 3] = mode;
  endtask

  task automatic soft_reset();
    reg_wr(A_SRST, 1);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 6; a++) begin reg_rd(a, rv); check("R1 register reset", rv, 0); end
    check("R1 s_ready reset", 32'(s_ready), 0);
    check("R1 mem_req reset", 32'(mem_req), 0);

    // table walk: single descriptor, various buffer/packet lengths (R2 R3 R4 R8 R10)
    for (int v = 0; v < NVEC; v++) begin
      int blen = int'(VECS[v][26:16]);
      int plen = int'(VECS[v][10:0]);
      logic [7:0] seed = 8'(16 * v + 3);
      bit ovf = plen > blen;
      int flen = ovf ? 3 : plen;
      logic [7:0] fseed = ovf ? 8'hA0 : seed;
      soft_reset();
      set_desc(32'h40, 0, 32'h100, blen, OWNED);
      for (int w = 0; w < 20; w++) mem[64 + w] = 32'hDEADBEEF;
      reg_wr(A_CTRL, 1); reg_wr(A_FREE, 1); reg_wr(A_HEAD, 32'h40);
      send_pkt(plen, seed, 0);
      if (ovf) begin
        reg_rd(A_STAT, rv); check("R10 overflow count", rv, 32'h100);
        reg_rd(A_HEAD, rv); check("R10 descriptor kept", rv, 32'h40);
        check("R10 mode untouched", mem[19], OWNED);
        send_pkt(3, 8'hA0, 0);
      end
      wait_head(0, 1);
      check("R4 status word", mem[19], 32'hD000_0000 | 32'(flen));
      for (int w = 0; w < (flen + 3) / 4; w++)
        check("R3 buffer word", mem[64 + w], exp_word(fseed, flen, w));
      if (!ovf) check("R3 word after packet untouched", mem[64 + (flen + 3) / 4], 32'hDEADBEEF);
      reg_rd(A_FREE, rv); check("R8 credit consumed", rv, 0);
    end

    // R9: disabled channel does not start
    soft_reset();
    set_desc(32'h40, 0, 32'h100, 32, OWNED);
    reg_wr(A_FREE, 1); reg_wr(A_HEAD, 32'h40);
    repeat (20) @(negedge clk);
    check("R9 no stream while disabled", 32'(s_ready), 0);
    check("R9 descriptor untouched", mem[19], OWNED);
    reg_wr(A_CTRL, 1);
    send_pkt(4, 8'h50, 0);
    wait_head(0, 1);
    check("R9 runs once enabled", mem[19], 32'hD000_0004);

    // R8: zero credit blocks, credit add and saturation
    soft_reset();
    set_desc(32'h40, 0, 32'h100, 32, OWNED);
    reg_wr(A_CTRL, 1); reg_wr(A_HEAD, 32'h40);
    repeat (20) @(negedge clk);
    check("R8 no start without credit", 32'(s_ready), 0);
    reg_wr(A_FREE, 3);
    reg_rd(A_FREE, rv); check("R8 credit added", rv, 3);
    send_pkt(2, 8'h60, 0);
    wait_head(0, 1);
    reg_rd(A_FREE, rv); check("R8 one credit used", rv, 2);
    reg_wr(A_FREE, 32'hFF); reg_wr(A_FREE, 5);
    reg_rd(A_FREE, rv); check("R8 credit saturates", rv, 32'hFF);

    // R7: descriptor not owned by the channel
    soft_reset();
    set_desc(32'h40, 0, 32'h100, 32, 32'h0);
    mem[64] = 32'h1234_5678;
    reg_wr(A_CTRL, 1); reg_wr(A_FREE, 1); reg_wr(A_HEAD, 32'h40);
    repeat (20) @(negedge clk);
    reg_rd(A_STAT, rv); check("R7 busy-clear flag", rv, 1);
    reg_rd(A_HEAD, rv); check("R7 head cleared", rv, 0);
    check("R7 mode not written", mem[19], 0);
    check("R7 buffer not written", mem[64], 32'h1234_5678);
    reg_wr(A_STAT, 1);
    reg_rd(A_STAT, rv); check("R7 flag cleared by write", rv, 0);

    // R5 R6: chain of two, busy head write, re-arm after end of queue
    soft_reset();
    set_desc(32'h40, 32'h50, 32'h100, 32, OWNED);
    set_desc(32'h50, 0, 32'h200, 32, OWNED);
    set_desc(32'h60, 0, 32'h300, 32, OWNED);
    reg_wr(A_CTRL, 1); reg_wr(A_FREE, 4); reg_wr(A_HEAD, 32'h40);
    while (!s_ready) @(negedge clk);
    reg_wr(A_HEAD, 32'h60);
    reg_rd(A_HEAD, rv); check("R6 head write while busy ignored", rv, 32'h40);
    send_pkt(6, 8'h10, 0);
    wait_head(32'h40, 0);
    reg_rd(A_HEAD, rv); check("R5 head follows next pointer", rv, 32'h50);
    send_pkt(7, 8'h20, 0);
    wait_head(0, 1);
    check("R5 first status no end of queue", mem[19], 32'hC000_0006);
    check("R5 last status end of queue", mem[23], 32'hD000_0007);
    check("R5 second buffer", mem[129], exp_word(8'h20, 7, 1));
    reg_wr(A_HEAD, 32'h60);
    send_pkt(2, 8'h30, 3);
    wait_head(0, 1);
    check("R6 re-armed descriptor done", mem[27], 32'hD000_0002);
    check("R3 bytes before start discarded", mem[192], exp_word(8'h30, 2, 0));
    reg_rd(A_FREE, rv); check("R8 three credits used", rv, 1);

    // R12 and R11
    reg_wr(A_CMPL, 32'hCAFE_0040);
    reg_rd(A_CMPL, rv); check("R12 completion readback", rv, 32'hCAFE_0040);
    reg_wr(A_CTRL, 1); reg_wr(A_HEAD, 32'h70);
    reg_wr(A_SRST, 1);
    @(negedge clk);
    reg_rd(A_SRST, rv); check("R11 soft reset self-clears", rv, 0);
    reg_rd(A_CTRL, rv); check("R11 control cleared", rv, 0);
    reg_rd(A_HEAD, rv); check("R11 head cleared", rv, 0);
    reg_rd(A_CMPL, rv); check("R11 completion cleared", rv, 0);
    reg_rd(A_FREE, rv); check("R11 credit cleared", rv, 0);
    check("R11 stream idle", 32'(s_ready), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule